// File: doc/BRIEF.md
# CAN Error-Warning Status Register

This block is the error and status word of a CAN controller as software reads it. It watches the transmit and receive error counters of the protocol engine. When either counter climbs to the warning level of 96, it records the event in a sticky flag. Software reads the word through a 32-bit read value and acknowledges a flag by writing a 1 to its bit. Each warning flag can also raise its own interrupt request, gated by a mask bit.

A global warning-enable input hides both warning flags without erasing them. A flag that is recorded while the enable is low shows up again as soon as the enable returns. Recording stops in two cases: a transmit warning is not recorded while the node is bus-off, and neither warning flag changes in any way while freeze mode is active.

The same word carries a live synchronization bit and a sticky bit-1 error flag. The bit-1 error flag is latched from a pulse supplied by the protocol engine.

Top module: `can_warn_stat`

## Requirements
- R1: A synchronous active-high reset clears both warning flags, the bit-1 error flag and the stored previous warning states, so that after reset only bit 18 (synchronization) can read 1.
- R2: The transmit warning flag (read bit 17) sets on the clock edge at which the transmit error counter is 96 or more, where on the previous edge it was below 96. A value of 95 does not set it.
- R3: A warning flag sets once per rising crossing. A counter that stays at or above 96 does not set the flag again after software clears it. A fresh crossing from below 96 does set it again.
- R4: The receive warning flag (read bit 16) follows the receive error counter under the same rule and is independent of the transmit flag.
- R5: A write clears a warning flag only when wrEn is 1, byte enable 2 is 1 (wrByteEn[k] qualifies wrData[8k+7:8k]) and the data bit at the flag's position is 1. Writing 0, or writing with byte enable 2 low, leaves the flag unchanged.
- R6: While warnEn is 0, read bits 17 and 16 are 0 and no warning interrupt is raised. The stored flags keep updating and reappear when warnEn returns to 1.
- R7: txWarnIrq is 1 exactly when the transmit flag is stored, warnEn is 1 and txWarnMask is 1. rxWarnIrq is 1 exactly when the receive flag is stored, warnEn is 1 and rxWarnMask is 1.
- R8: While busOff is 1, the transmit warning flag does not set, even on a crossing. The receive flag is unaffected. A crossing that happened during bus-off is not recorded once busOff drops.
- R9: While freezeMode is 1, neither warning flag changes, whether by a set or by a software clear. A crossing that happens during freeze is not recorded after freeze ends.
- R10: Read bit 18 mirrors syncOk in the same cycle. Bits 31 to 19 and 14 to 0 always read 0.
- R11: Read bit 15 latches to 1 on a bit1ErrPulse and stays set. It is cleared by writing 1 to bit 15 with byte enable 1 high.
- R12: When a hardware set and a software clear of the same flag fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| txErrCnt | input | 8 | Transmit error counter |
| rxErrCnt | input | 8 | Receive error counter |
| busOff | input | 1 | Node is in bus-off state |
| freezeMode | input | 1 | Controller is frozen |
| syncOk | input | 1 | Node is synchronized to the bus |
| warnEn | input | 1 | Global enable for the warning flags |
| txWarnMask | input | 1 | Interrupt mask for the transmit warning |
| rxWarnMask | input | 1 | Interrupt mask for the receive warning |
| bit1ErrPulse | input | 1 | One-cycle bit-1 error indication |
| wrEn | input | 1 | Register write strobe |
| wrByteEn | input | 4 | Byte lane enables for the write |
| wrData | input | 32 | Write data, 1 clears the matching flag |
| rdData | output | 32 | Status word |
| txWarnIrq | output | 1 | Transmit warning interrupt request |
| rxWarnIrq | output | 1 | Receive warning interrupt request |

## Verification
The hardest case to reach is a counter crossing that must be lost: the edge has to happen during freeze or bus-off, and the counter must still be above 96 when the condition lifts, so that a naive level check would wrongly set the flag afterwards. The stimulus first drops each counter below 96 to re-arm the edge detector. It then raises the counter while the blocking input is held, releases the input with the counter unchanged, and reads the flag. A same-cycle collision of a counter crossing with a write-1 clear is driven in a single write cycle to show that the set wins.

// File: rtl/can_warn_pkg.sv
package can_warn_pkg;
  // Channel indices for the two warning paths
  localparam int RX_CH = 0;
  localparam int TX_CH = 1;
  localparam int N_CH  = 2;

  // Bit positions in the status word (software decodes these)
  localparam int SYNC_BIT    = 18;
  localparam int TX_WARN_BIT = 17;
  localparam int RX_WARN_BIT = 16;
  localparam int BIT1_BIT    = 15;

  // Strobes from control to datapath
  typedef struct packed {
    logic [N_CH-1:0] setWarn;
    logic [N_CH-1:0] clrWarn;
    logic            setBit1;
    logic            clrBit1;
    logic            hold;
  } warnStrobe_t;
endpackage

// File: rtl/can_warn_ctrl.sv
module can_warn_ctrl
  import can_warn_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int WARN_LIMIT = 96,
  parameter int DATA_W     = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  txErrCnt,
  input  logic [CNT_W-1:0]  rxErrCnt,
  input  logic              busOff,
  input  logic              freezeMode,
  input  logic              bit1ErrPulse,
  input  logic              wrEn,
  input  logic [DATA_W/8-1:0] wrByteEn,
  input  logic [DATA_W-1:0] wrData,
  output warnStrobe_t       stb
);
  localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(WARN_LIMIT);
  localparam int TX_LANE = TX_WARN_BIT / 8;
  localparam int RX_LANE = RX_WARN_BIT / 8;
  localparam int B1_LANE = BIT1_BIT / 8;

  logic [N_CH-1:0][CNT_W-1:0] errCnt;
  logic [N_CH-1:0] warnNow;
  logic [N_CH-1:0] warnPrev;
  logic [N_CH-1:0] blockSet;
  logic [N_CH-1:0] warnRise;
  logic [N_CH-1:0] clrHit;
  logic unusedWr;

  assign errCnt[RX_CH] = rxErrCnt;
  assign errCnt[TX_CH] = txErrCnt;

  // Bus-off only suppresses the transmit path
  assign blockSet[RX_CH] = 1'b0;
  assign blockSet[TX_CH] = busOff;

  // Write-1-to-clear decode per lane
  assign clrHit[TX_CH] = wrEn && wrByteEn[TX_LANE] && wrData[TX_WARN_BIT];
  assign clrHit[RX_CH] = wrEn && wrByteEn[RX_LANE] && wrData[RX_WARN_BIT];

  always_comb begin
    for (int ch = 0; ch < N_CH; ch++) begin
      warnNow[ch]  = (errCnt[ch] >= LIMIT_V);
      warnRise[ch] = warnNow[ch] && !warnPrev[ch];
    end
  end

  // Previous level keeps tracking through freeze and bus-off,
  // so an edge hidden by either is consumed, not deferred.
  always_ff @(posedge clk) begin
    if (rst) warnPrev <= '0;
    else     warnPrev <= warnNow;
  end

  always_comb begin
    stb         = '0;
    stb.hold    = freezeMode;
    stb.setWarn = warnRise & ~blockSet & {N_CH{!freezeMode}};
    stb.clrWarn = clrHit;
    stb.setBit1 = bit1ErrPulse;
    stb.clrBit1 = wrEn && wrByteEn[B1_LANE] && wrData[BIT1_BIT];
  end

  assign unusedWr = ^{wrData, wrByteEn};
endmodule

// File: rtl/can_warn_dp.sv
module can_warn_dp
  import can_warn_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  warnStrobe_t       stb,
  input  logic              syncOk,
  input  logic              warnEn,
  input  logic              txWarnMask,
  input  logic              rxWarnMask,
  output logic [N_CH-1:0]   warnFlag,
  output logic [DATA_W-1:0] rdData,
  output logic              txWarnIrq,
  output logic              rxWarnIrq
);
  logic bit1Flag;
  logic [N_CH-1:0] warnVis;

  // Sticky warning flags: set beats clear, hold freezes both
  always_ff @(posedge clk) begin
    if (rst) begin
      warnFlag <= '0;
    end else if (!stb.hold) begin
      for (int ch = 0; ch < N_CH; ch++) begin
        if (stb.setWarn[ch])      warnFlag[ch] <= 1'b1;
        else if (stb.clrWarn[ch]) warnFlag[ch] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)              bit1Flag <= 1'b0;
    else if (stb.setBit1) bit1Flag <= 1'b1;
    else if (stb.clrBit1) bit1Flag <= 1'b0;
  end

  assign warnVis = warnFlag & {N_CH{warnEn}};

  always_comb begin
    rdData              = '0;
    rdData[SYNC_BIT]    = syncOk;
    rdData[TX_WARN_BIT] = warnVis[TX_CH];
    rdData[RX_WARN_BIT] = warnVis[RX_CH];
    rdData[BIT1_BIT]    = bit1Flag;
  end

  assign txWarnIrq = warnVis[TX_CH] && txWarnMask;
  assign rxWarnIrq = warnVis[RX_CH] && rxWarnMask;
endmodule

// File: rtl/can_warn_stat.sv
module can_warn_stat
  import can_warn_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int WARN_LIMIT = 96
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] txErrCnt,
  input  logic [CNT_W-1:0] rxErrCnt,
  input  logic             busOff,
  input  logic             freezeMode,
  input  logic             syncOk,
  input  logic             warnEn,
  input  logic             txWarnMask,
  input  logic             rxWarnMask,
  input  logic             bit1ErrPulse,
  input  logic             wrEn,
  input  logic [3:0]       wrByteEn,
  input  logic [31:0]      wrData,
  output logic [31:0]      rdData,
  output logic             txWarnIrq,
  output logic             rxWarnIrq
);
  warnStrobe_t stb;
  logic [N_CH-1:0] warnFlagQ;

  can_warn_ctrl #(
    .CNT_W(CNT_W), .WARN_LIMIT(WARN_LIMIT), .DATA_W(32)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .txErrCnt(txErrCnt), .rxErrCnt(rxErrCnt),
    .busOff(busOff), .freezeMode(freezeMode),
    .bit1ErrPulse(bit1ErrPulse),
    .wrEn(wrEn), .wrByteEn(wrByteEn), .wrData(wrData),
    .stb(stb)
  );

  can_warn_dp #(.DATA_W(32)) u_dp (
    .clk(clk), .rst(rst), .stb(stb),
    .syncOk(syncOk), .warnEn(warnEn),
    .txWarnMask(txWarnMask), .rxWarnMask(rxWarnMask),
    .warnFlag(warnFlagQ), .rdData(rdData),
    .txWarnIrq(txWarnIrq), .rxWarnIrq(rxWarnIrq)
  );
endmodule

// File: rtl/can_warn_chk.sv
module can_warn_chk #(
  parameter int CNT_W      = 8,
  parameter int WARN_LIMIT = 96
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] txErrCnt,
  input logic [CNT_W-1:0] rxErrCnt,
  input logic             busOff,
  input logic             freezeMode,
  input logic             syncOk,
  input logic             warnEn,
  input logic             txWarnMask,
  input logic             rxWarnMask,
  input logic [31:0]      rdData,
  input logic             txWarnIrq,
  input logic             rxWarnIrq,
  input logic [1:0]       warnFlag
);
  localparam logic [CNT_W-1:0] LIM = CNT_W'(WARN_LIMIT);

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (warnFlag == 2'b00 && rdData[15] == 1'b0));

  a_r2_tx_crossing_sets: assert property (@(posedge clk) disable iff (rst)
    (txErrCnt >= LIM && $past(txErrCnt) < LIM && !busOff && !freezeMode)
      |=> warnFlag[1]);

  a_r4_rx_crossing_sets: assert property (@(posedge clk) disable iff (rst)
    (rxErrCnt >= LIM && $past(rxErrCnt) < LIM && !freezeMode)
      |=> warnFlag[0]);

  a_r3_no_reset_while_high: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(txErrCnt) >= LIM && txErrCnt >= LIM && !warnFlag[1])
      |=> !warnFlag[1]);

  a_r6_hidden_when_disabled: assert property (@(posedge clk) disable iff (rst)
    !warnEn |-> (rdData[17:16] == 2'b00 && !txWarnIrq && !rxWarnIrq));

  a_r7_tx_irq: assert property (@(posedge clk) disable iff (rst)
    txWarnIrq == (warnEn && txWarnMask && warnFlag[1]));

  a_r7_rx_irq: assert property (@(posedge clk) disable iff (rst)
    rxWarnIrq == (warnEn && rxWarnMask && warnFlag[0]));

  a_r8_busoff_blocks_tx: assert property (@(posedge clk) disable iff (rst)
    (busOff && !warnFlag[1]) |=> !warnFlag[1]);

  a_r9_freeze_holds: assert property (@(posedge clk) disable iff (rst)
    freezeMode |=> $stable(warnFlag));

  a_r10_word_layout: assert property (@(posedge clk) disable iff (rst)
    rdData[31:19] == '0 && rdData[14:0] == '0 && rdData[18] == syncOk);
endmodule

bind can_warn_stat can_warn_chk #(.CNT_W(CNT_W), .WARN_LIMIT(WARN_LIMIT)) u_chk (
  .clk(clk), .rst(rst), .txErrCnt(txErrCnt), .rxErrCnt(rxErrCnt),
  .busOff(busOff), .freezeMode(freezeMode), .syncOk(syncOk),
  .warnEn(warnEn), .txWarnMask(txWarnMask), .rxWarnMask(rxWarnMask),
  .rdData(rdData), .txWarnIrq(txWarnIrq), .rxWarnIrq(rxWarnIrq),
  .warnFlag(warnFlagQ)
);

// File: tb/can_warn_stat_tb.sv
module can_warn_stat_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] txErrCnt = '0, rxErrCnt = '0;
  logic busOff = 0, freezeMode = 0, syncOk = 1, warnEn = 1;
  logic txWarnMask = 0, rxWarnMask = 0, bit1ErrPulse = 0;
  logic wrEn = 0;
  logic [3:0] wrByteEn = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic txWarnIrq, rxWarnIrq;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  always #5 clk = ~clk;

  can_warn_stat u_dut (
    .clk(clk), .rst(rst), .txErrCnt(txErrCnt), .rxErrCnt(rxErrCnt),
    .busOff(busOff), .freezeMode(freezeMode), .syncOk(syncOk),
    .warnEn(warnEn), .txWarnMask(txWarnMask), .rxWarnMask(rxWarnMask),
    .bit1ErrPulse(bit1ErrPulse), .wrEn(wrEn), .wrByteEn(wrByteEn),
    .wrData(wrData), .rdData(rdData), .txWarnIrq(txWarnIrq),
    .rxWarnIrq(rxWarnIrq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic setCnt(logic [7:0] tx, logic [7:0] rx);
    txErrCnt = tx;
    rxErrCnt = rx;
    step();
  endtask

  task automatic doWrite(logic [3:0] be, logic [31:0] d);
    wrEn = 1; wrByteEn = be; wrData = d;
    step();
    wrEn = 0; wrByteEn = '0; wrData = '0;
  endtask

  task automatic t_reset();
    rst = 1;
    setCnt(0, 0);
    step();
    rst = 0;
    step();
    check("R1 reset word", rdData, 32'h0004_0000);
    check("R1 reset irq", {30'b0, txWarnIrq, rxWarnIrq}, 32'h0);
  endtask

  task automatic t_threshold();
    setCnt(95, 0);
    check("R2 95 no set", rdData[17], 1'b0);
    setCnt(96, 0);
    check("R2 96 sets", rdData[17], 1'b1);
    doWrite(4'b0100, 32'h0002_0000);
    check("R5 clear tx", rdData[17], 1'b0);
    setCnt(120, 0);
    check("R3 stays high no reset", rdData[17], 1'b0);
    setCnt(50, 0);
    setCnt(200, 0);
    check("R3 new crossing sets", rdData[17], 1'b1);
    doWrite(4'b0100, 32'h0002_0000);
  endtask

  task automatic t_rx();
    setCnt(200, 96);
    check("R4 rx sets, tx clear", rdData[17:16], 2'b01);
    setCnt(200, 97);
    doWrite(4'b0100, 32'h0001_0000);
    check("R4 rx cleared", rdData[17:16], 2'b00);
    setCnt(0, 0);
  endtask

  task automatic t_w1c();
    setCnt(100, 100);
    check("R5 both set", rdData[17:16], 2'b11);
    doWrite(4'b0100, 32'h0000_0000);
    check("R5 write zero", rdData[17:16], 2'b11);
    doWrite(4'b1011, 32'h0003_0000);
    check("R5 lane off", rdData[17:16], 2'b11);
    doWrite(4'b0100, 32'h0002_0000);
    check("R5 tx only cleared", rdData[17:16], 2'b01);
    doWrite(4'b0100, 32'h0001_0000);
    check("R5 rx cleared", rdData[17:16], 2'b00);
  endtask

  task automatic t_enable();
    setCnt(0, 0);
    warnEn = 0;
    txWarnMask = 1;
    setCnt(100, 0);
    check("R6 hidden bit", rdData[17], 1'b0);
    check("R6 no irq", txWarnIrq, 1'b0);
    warnEn = 1;
    #1;
    check("R6 reappears", rdData[17], 1'b1);
    check("R7 tx irq", txWarnIrq, 1'b1);
    txWarnMask = 0;
    #1;
    check("R7 tx masked", txWarnIrq, 1'b0);
    rxWarnMask = 1;
    setCnt(100, 100);
    check("R7 rx irq", {txWarnIrq, rxWarnIrq}, 2'b01);
    doWrite(4'b0100, 32'h0003_0000);
    check("R7 rx irq drops", rxWarnIrq, 1'b0);
    rxWarnMask = 0;
  endtask

  task automatic t_busoff();
    setCnt(0, 0);
    busOff = 1;
    setCnt(100, 100);
    check("R8 tx blocked, rx set", rdData[17:16], 2'b01);
    busOff = 0;
    step();
    check("R8 edge lost after bus-off", rdData[17], 1'b0);
    doWrite(4'b0100, 32'h0001_0000);
  endtask

  task automatic t_freeze();
    setCnt(0, 0);
    setCnt(100, 0);
    freezeMode = 1;
    doWrite(4'b0100, 32'h0002_0000);
    check("R9 clear ignored", rdData[17], 1'b1);
    setCnt(100, 100);
    check("R9 set ignored", rdData[16], 1'b0);
    freezeMode = 0;
    step();
    check("R9 edge lost after freeze", rdData[16], 1'b0);
    doWrite(4'b0100, 32'h0002_0000);
    check("R9 clear after freeze", rdData[17], 1'b0);
  endtask

  task automatic t_bit1();
    bit1ErrPulse = 1;
    step();
    bit1ErrPulse = 0;
    step();
    check("R11 latched", rdData[15], 1'b1);
    doWrite(4'b1101, 32'h0000_8000);
    check("R11 lane off", rdData[15], 1'b1);
    doWrite(4'b0010, 32'h0000_8000);
    check("R11 cleared", rdData[15], 1'b0);
  endtask

  task automatic t_collide();
    setCnt(0, 0);
    txErrCnt = 100;
    bit1ErrPulse = 1;
    doWrite(4'b0110, 32'h0002_8000);
    bit1ErrPulse = 0;
    check("R12 set wins tx", rdData[17], 1'b1);
    check("R12 set wins bit1", rdData[15], 1'b1);
  endtask

  task automatic t_layout();
    syncOk = 0;
    #1;
    check("R10 sync mirror low", rdData[18], 1'b0);
    check("R10 reserved zero", rdData & 32'hFFF8_7FFF, 32'h0);
    syncOk = 1;
    #1;
    check("R10 sync mirror high", rdData[18], 1'b1);
    doWrite(4'b0110, 32'h0002_8000);
    check("R10 cleared word", rdData, 32'h0004_0000);
  endtask

  task automatic t_reset_again();
    setCnt(0, 0);
    setCnt(100, 100);
    bit1ErrPulse = 1;
    step();
    bit1ErrPulse = 0;
    setCnt(0, 0);
    rst = 1;
    step();
    rst = 0;
    step();
    check("R1 reset clears flags", rdData, 32'h0004_0000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_threshold();
    t_rx();
    t_w1c();
    t_enable();
    t_busoff();
    t_freeze();
    t_bit1();
    t_collide();
    t_layout();
    t_reset_again();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule